// File: doc/BRIEF.md
# Banked Data Memory Address Controller

This block is the data-memory front end of a small 8-bit processor core. Each cycle it turns an operation into a 12-bit data address. The address comes from one of three sources. The first joins a 4-bit bank register with an 8-bit offset taken from the instruction. The second is a fixed access window that needs no bank register. The third is a pair of complete 12-bit addresses used by a memory-to-memory move. The block holds the bank register and the static RAM behind it. The high end of the address space, where the control registers live, is routed to an external register port instead of the RAM.

The address space is 4096 bytes, cut into sixteen banks of 256 bytes. A 16-bit parameter mask says which banks have RAM behind them. Only the implemented banks take up storage, because their bytes are packed into one compact array. A write into a missing bank is dropped and a read from one returns zero. The operation still reports completion, so the core's status logic goes on as if the access had worked.

Reads are combinational from the resolved address. RAM writes, register-port writes and bank register loads all take effect on the rising clock edge.

Top module: `dmem_addr_unit`

## Requirements
- R1: With `op_mode` = 0 (banked), the effective read and write address is the bank register value in bits 11:8 and `op_offset` in bits 7:0. Code 3 is reserved and resolves the same way as code 0.
- R2: When `bsr_load` is high at a rising edge, the bank register takes `bsr_lit[3:0]`. `bsr_q` shows the register in bits 3:0 and always reads 0 in bits 7:4. Operations in the load cycle still use the old bank value.
- R3: With `op_mode` = 1 (access), offsets 0x00–0x5F map to addresses 0x000–0x05F and offsets 0x60–0xFF map to 0xF60–0xFFF, whatever the bank register holds.
- R4: With `op_mode` = 2 (full move), the read address is `mv_src` and the write address is `mv_dst`. The bank register is ignored. When `op_valid` is high, the byte read from the source is written to the destination at the edge, whatever `op_write` is.
- R5: In modes 0, 1 and 3, a write commits `op_wdata` at the rising edge when `op_valid` and `op_write` are both high. `rd_data` follows the resolved read address within the same cycle.
- R6: A bank whose bit in `BANK_MASK` is 0 is unimplemented. A write to it changes no stored byte, and a read from it returns 0x00.
- R7: Addresses 0xF60–0xFFF form the register window. A read there returns `sfr_rd_data` for the low byte on `sfr_rd_addr`. A write there pulses `sfr_wr_en` with `sfr_wr_addr` and `sfr_wr_data` and is not stored in RAM.
- R8: `op_done` is high in the cycle after every cycle in which `op_valid` was high, including accesses to unimplemented space, and is low otherwise.
- R9: A synchronous reset clears the bank register and `op_done` to 0. RAM contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | An operation is presented this cycle |
| op_mode | input | 2 | 0 banked, 1 access window, 2 full move, 3 reserved (as banked) |
| op_write | input | 1 | Write request in modes 0, 1 and 3 |
| op_offset | input | 8 | Offset field of the instruction |
| op_wdata | input | 8 | Write data in modes 0, 1 and 3 |
| mv_src | input | 12 | Full source address in move mode |
| mv_dst | input | 12 | Full destination address in move mode |
| bsr_load | input | 1 | Load the bank register from the literal |
| bsr_lit | input | 8 | Literal for the bank register |
| bsr_q | output | 8 | Bank register value, upper bits zero |
| eff_rd_addr | output | 12 | Resolved read address |
| eff_wr_addr | output | 12 | Resolved write address |
| rd_data | output | 8 | Read data for the resolved read address |
| op_done | output | 1 | Completion, one cycle after op_valid |
| sfr_rd_addr | output | 8 | Low byte of the read address for the register port |
| sfr_rd_data | input | 8 | Register port read data |
| sfr_wr_en | output | 1 | Register port write strobe |
| sfr_wr_addr | output | 8 | Register port write address low byte |
| sfr_wr_data | output | 8 | Register port write data |

## Verification
The bench aims at the access window split at offsets 0x5F and 0x60. A design that put the split in the wrong place would send bank-0 RAM traffic to the register port, or register traffic into RAM. It loads literals with upper bits set and checks that those bits never appear. It also checks that a load has no effect on an operation issued in the same cycle. It moves data with full addresses under a bank value that disagrees with the source, which shows up any leak of the bank register into the move path. It reads and writes the banks that have no RAM. A compact storage map with the wrong slot count would alias them onto real banks, and the readback of real banks, plus the zero reads of missing ones, would expose that.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

   typedef enum logic [1:0] {
      AM_BANKED = 2'd0,
      AM_ACCESS = 2'd1,
      AM_FULL   = 2'd2,
      AM_RSVD   = 2'd3
   } addr_mode_e;

   // number of set bits in mask below position lim
   function automatic int unsigned ones_below(input logic [63:0] mask, input int unsigned lim);
      int unsigned n;
      n = 0;
      for (int unsigned i = 0; i < 64; i++) begin
         if (i < lim && mask[i]) n++;
      end
      return n;
   endfunction

endpackage

// File: rtl/dmem_bank_reg.sv
module dmem_bank_reg #(
   parameter int BANK_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] lit,
   output logic [BANK_W-1:0] bank,
   output logic [DATA_W-1:0] view
);

   if (DATA_W <= BANK_W) begin : g_bad_width
      $error("dmem_bank_reg: DATA_W must exceed BANK_W");
   end

   localparam int PAD_W = DATA_W - BANK_W;

   logic [BANK_W-1:0] bank_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         bank_q <= '0;
      end else if (load) begin
         bank_q <= lit[BANK_W-1:0];
      end
   end

   assign bank = bank_q;
   assign view = {{PAD_W{1'b0}}, bank_q};

   // R2
   bank_load_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> bank_q == $past(lit[BANK_W-1:0]));

   // R9
   bank_reset_chk: assert property (@(posedge clk)
      rst |=> bank_q == '0);

endmodule

// File: rtl/dmem_resolve.sv
module dmem_resolve
   import dmem_pkg::*;
#(
   parameter int          BANK_W    = 4,
   parameter int          OFF_W     = 8,
   parameter int unsigned ACC_SPLIT = 8'h60,
   localparam int         ADDR_W    = BANK_W + OFF_W
) (
   input  addr_mode_e        mode,
   input  logic [OFF_W-1:0]  offset,
   input  logic [BANK_W-1:0] bank,
   input  logic [ADDR_W-1:0] src,
   input  logic [ADDR_W-1:0] dst,
   output logic [ADDR_W-1:0] rd_addr,
   output logic [ADDR_W-1:0] wr_addr
);

   if (ACC_SPLIT >= (1 << OFF_W)) begin : g_bad_split
      $error("dmem_resolve: ACC_SPLIT outside one bank");
   end

   localparam logic [BANK_W-1:0] LOW_BANK = '0;
   localparam logic [BANK_W-1:0] TOP_BANK = '1;
   localparam logic [OFF_W-1:0]  SPLIT_V  = OFF_W'(ACC_SPLIT);

   logic [ADDR_W-1:0] banked_a;
   logic [ADDR_W-1:0] access_a;

   assign banked_a = {bank, offset};
   assign access_a = (offset < SPLIT_V) ? {LOW_BANK, offset} : {TOP_BANK, offset};

   always_comb begin
      unique case (mode)
         AM_ACCESS: begin
            rd_addr = access_a;
            wr_addr = access_a;
         end
         AM_FULL: begin
            rd_addr = src;
            wr_addr = dst;
         end
         default: begin
            rd_addr = banked_a;
            wr_addr = banked_a;
         end
      endcase
   end

endmodule

// File: rtl/dmem_decode.sv
module dmem_decode #(
   parameter int              BANK_W    = 4,
   parameter int              OFF_W     = 8,
   parameter logic [63:0]     BANK_MASK = 64'h8025,
   parameter int unsigned     ACC_SPLIT = 8'h60,
   parameter int              SLOT_W    = 2,
   localparam int             ADDR_W    = BANK_W + OFF_W,
   localparam int             NUM_BANKS = 1 << BANK_W
) (
   input  logic [ADDR_W-1:0]       addr,
   output logic                    is_sfr,
   output logic                    is_ram,
   output logic [SLOT_W+OFF_W-1:0] ram_idx
);

   localparam logic [BANK_W-1:0] TOP_BANK  = '1;
   localparam logic [OFF_W-1:0]  SPLIT_V   = OFF_W'(ACC_SPLIT);
   localparam logic [NUM_BANKS-1:0] MASK_N = BANK_MASK[NUM_BANKS-1:0];
   localparam bit FULL_MAP = (MASK_N == {NUM_BANKS{1'b1}});

   logic [BANK_W-1:0] bank_f;
   logic [OFF_W-1:0]  off_f;
   logic [SLOT_W-1:0] slot;

   assign bank_f = addr[ADDR_W-1:OFF_W];
   assign off_f  = addr[OFF_W-1:0];
   assign is_sfr = (bank_f == TOP_BANK) && (off_f >= SPLIT_V);
   assign is_ram = MASK_N[bank_f] && !is_sfr;

   if (FULL_MAP) begin : g_direct
      if (SLOT_W != BANK_W) begin : g_bad_slot
         $error("dmem_decode: full map needs SLOT_W == BANK_W");
      end
      assign slot = SLOT_W'(bank_f);
   end else begin : g_packed
      always_comb begin
         slot = '0;
         for (int i = 0; i < NUM_BANKS; i++) begin
            if (i < int'(bank_f) && MASK_N[i]) slot = slot + 1'b1;
         end
      end
   end

   assign ram_idx = {slot, off_f};

endmodule

// File: rtl/dmem_sram.sv
module dmem_sram #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 1024,
   parameter int AW     = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);

   if ((1 << AW) < DEPTH) begin : g_bad_aw
      $error("dmem_sram: AW too narrow for DEPTH");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;

   // R6
   sram_range_chk: assert property (@(posedge clk)
      we |-> int'(waddr) < DEPTH);

endmodule

// File: rtl/dmem_addr_unit.sv
module dmem_addr_unit
   import dmem_pkg::*;
#(
   parameter int          BANK_W    = 4,
   parameter int          OFF_W     = 8,
   parameter int          DATA_W    = 8,
   parameter logic [15:0] BANK_MASK = 16'h8025,
   parameter int unsigned ACC_SPLIT = 8'h60
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     op_valid,
   input  logic [1:0]               op_mode,
   input  logic                     op_write,
   input  logic [OFF_W-1:0]         op_offset,
   input  logic [DATA_W-1:0]        op_wdata,
   input  logic [BANK_W+OFF_W-1:0]  mv_src,
   input  logic [BANK_W+OFF_W-1:0]  mv_dst,
   input  logic                     bsr_load,
   input  logic [DATA_W-1:0]        bsr_lit,
   output logic [DATA_W-1:0]        bsr_q,
   output logic [BANK_W+OFF_W-1:0]  eff_rd_addr,
   output logic [BANK_W+OFF_W-1:0]  eff_wr_addr,
   output logic [DATA_W-1:0]        rd_data,
   output logic                     op_done,
   output logic [OFF_W-1:0]         sfr_rd_addr,
   input  logic [DATA_W-1:0]        sfr_rd_data,
   output logic                     sfr_wr_en,
   output logic [OFF_W-1:0]         sfr_wr_addr,
   output logic [DATA_W-1:0]        sfr_wr_data
);

   localparam int ADDR_W    = BANK_W + OFF_W;
   localparam int NUM_BANKS = 1 << BANK_W;
   localparam int BANK_SIZE = 1 << OFF_W;
   localparam int NUM_IMPL  = $countones(BANK_MASK);
   localparam bit FULL_MAP  = (NUM_IMPL == NUM_BANKS);
   localparam int SLOT_W    = FULL_MAP ? BANK_W : ((NUM_IMPL > 1) ? $clog2(NUM_IMPL) : 1);
   localparam int RAM_DEPTH = NUM_IMPL * BANK_SIZE;
   localparam int RAM_AW    = SLOT_W + OFF_W;

   if (NUM_BANKS > 16) begin : g_bad_banks
      $error("dmem_addr_unit: BANK_MASK covers at most 16 banks");
   end
   if (NUM_IMPL == 0) begin : g_no_ram
      $error("dmem_addr_unit: BANK_MASK selects no bank");
   end
   if (ACC_SPLIT == 0 || ACC_SPLIT >= BANK_SIZE) begin : g_bad_split
      $error("dmem_addr_unit: ACC_SPLIT must fall inside one bank");
   end

   addr_mode_e        mode;
   logic [BANK_W-1:0] bank;
   logic [ADDR_W-1:0] rd_a, wr_a;
   logic              rd_sfr, rd_ram, wr_sfr, wr_ram;
   logic [RAM_AW-1:0] rd_idx, wr_idx;
   logic [DATA_W-1:0] ram_q;
   logic              commit;
   logic [DATA_W-1:0] commit_data;
   logic              ram_we;
   logic              done_q;

   assign mode = addr_mode_e'(op_mode);

   dmem_bank_reg #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_bank (
      .clk  (clk),
      .rst  (rst),
      .load (bsr_load),
      .lit  (bsr_lit),
      .bank (bank),
      .view (bsr_q)
   );

   dmem_resolve #(.BANK_W(BANK_W), .OFF_W(OFF_W), .ACC_SPLIT(ACC_SPLIT)) u_resolve (
      .mode    (mode),
      .offset  (op_offset),
      .bank    (bank),
      .src     (mv_src),
      .dst     (mv_dst),
      .rd_addr (rd_a),
      .wr_addr (wr_a)
   );

   dmem_decode #(
      .BANK_W(BANK_W), .OFF_W(OFF_W), .BANK_MASK(64'(BANK_MASK)),
      .ACC_SPLIT(ACC_SPLIT), .SLOT_W(SLOT_W)
   ) u_rd_dec (
      .addr    (rd_a),
      .is_sfr  (rd_sfr),
      .is_ram  (rd_ram),
      .ram_idx (rd_idx)
   );

   dmem_decode #(
      .BANK_W(BANK_W), .OFF_W(OFF_W), .BANK_MASK(64'(BANK_MASK)),
      .ACC_SPLIT(ACC_SPLIT), .SLOT_W(SLOT_W)
   ) u_wr_dec (
      .addr    (wr_a),
      .is_sfr  (wr_sfr),
      .is_ram  (wr_ram),
      .ram_idx (wr_idx)
   );

   dmem_sram #(.DATA_W(DATA_W), .DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
      .clk   (clk),
      .we    (ram_we),
      .waddr (wr_idx),
      .wdata (commit_data),
      .raddr (rd_idx),
      .rdata (ram_q)
   );

   always_comb begin
      if (rd_sfr)      rd_data = sfr_rd_data;
      else if (rd_ram) rd_data = ram_q;
      else             rd_data = '0;
   end

   assign commit      = op_valid && ((mode == AM_FULL) || op_write);
   assign commit_data = (mode == AM_FULL) ? rd_data : op_wdata;
   assign ram_we      = commit && wr_ram;

   assign sfr_rd_addr = rd_a[OFF_W-1:0];
   assign sfr_wr_en   = commit && wr_sfr;
   assign sfr_wr_addr = wr_a[OFF_W-1:0];
   assign sfr_wr_data = commit_data;

   always_ff @(posedge clk) begin
      if (rst) done_q <= 1'b0;
      else     done_q <= op_valid;
   end

   assign op_done     = done_q;
   assign eff_rd_addr = rd_a;
   assign eff_wr_addr = wr_a;

   // R8
   done_after_op_chk: assert property (@(posedge clk) disable iff (rst)
      op_valid |=> op_done);

   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> !op_done);

   // R7
   sfr_not_ram_chk: assert property (@(posedge clk) disable iff (rst)
      sfr_wr_en |-> !ram_we);

   // R3
   access_window_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == AM_ACCESS) |-> (rd_a[ADDR_W-1:OFF_W] == '0 || rd_a[ADDR_W-1:OFF_W] == '1));

   // R6
   missing_bank_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (!BANK_MASK[rd_a[ADDR_W-1:OFF_W]] && !rd_sfr) |-> rd_data == '0);

   // R4
   move_uses_src_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == AM_FULL) |-> (eff_rd_addr == mv_src && eff_wr_addr == mv_dst));

endmodule

// File: tb/tb_dmem_addr_unit.sv
module tb_dmem_addr_unit;

   localparam logic [15:0] MASK  = 16'h8025;
   localparam int          SPLIT = 8'h60;

   logic        clk = 1'b0;
   logic        rst;
   logic        op_valid, op_write, bsr_load;
   logic [1:0]  op_mode;
   logic [7:0]  op_offset, op_wdata, bsr_lit;
   logic [11:0] mv_src, mv_dst;
   logic [7:0]  bsr_q, rd_data, sfr_rd_addr, sfr_wr_addr, sfr_wr_data, sfr_rd_data;
   logic [11:0] eff_rd_addr, eff_wr_addr;
   logic        op_done, sfr_wr_en;

   always #10 clk = ~clk;

   assign sfr_rd_data = sfr_rd_addr ^ 8'h5A;

   dmem_addr_unit dut (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_mode(op_mode), .op_write(op_write),
      .op_offset(op_offset), .op_wdata(op_wdata), .mv_src(mv_src), .mv_dst(mv_dst),
      .bsr_load(bsr_load), .bsr_lit(bsr_lit), .bsr_q(bsr_q), .eff_rd_addr(eff_rd_addr),
      .eff_wr_addr(eff_wr_addr), .rd_data(rd_data), .op_done(op_done),
      .sfr_rd_addr(sfr_rd_addr), .sfr_rd_data(sfr_rd_data), .sfr_wr_en(sfr_wr_en),
      .sfr_wr_addr(sfr_wr_addr), .sfr_wr_data(sfr_wr_data)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   // reference state
   int m_bank = 0;
   bit m_done = 0;
   int m_mem [4096];
   bit m_known [4096];

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int resolve(input int mode, input int off, input int full);
      if (mode == 1) return (off < SPLIT) ? off : (12'hF00 | off);
      if (mode == 2) return full;
      return (m_bank << 8) | off;
   endfunction

   function automatic bit in_sfr(input int a);
      return a >= 12'hF60;
   endfunction

   // -1 means not yet known
   function automatic int read_model(input int a);
      if (in_sfr(a)) return (a & 8'hFF) ^ 8'h5A;
      if (!MASK[a >> 8]) return 0;
      if (m_known[a]) return m_mem[a];
      return -1;
   endfunction

   task automatic step(input bit v, input int mode, input bit w, input int off,
                       input int wd, input int src, input int dst,
                       input bit ld, input int lit);
      int ra, wa, rv, cdata;
      bit commit;
      string tag;
      @(negedge clk);
      op_valid = v; op_mode = 2'(mode); op_write = w; op_offset = 8'(off);
      op_wdata = 8'(wd); mv_src = 12'(src); mv_dst = 12'(dst);
      bsr_load = ld; bsr_lit = 8'(lit);
      #5;
      tag = (mode == 1) ? "R3" : (mode == 2) ? "R4" : "R1";
      ra = resolve(mode, off, src);
      wa = resolve(mode, off, (mode == 2) ? dst : src);
      chk(tag, int'(eff_rd_addr), ra);
      chk(tag, int'(eff_wr_addr), wa);
      chk("R2", int'(bsr_q), m_bank);
      chk("R8", int'(op_done), int'(m_done));
      rv = read_model(ra);
      if (rv >= 0) begin
         if (in_sfr(ra))          chk("R7", int'(rd_data), rv);
         else if (!MASK[ra >> 8]) chk("R6", int'(rd_data), rv);
         else                     chk("R5", int'(rd_data), rv);
      end
      commit = v && (mode == 2 || w);
      cdata  = (mode == 2) ? rv : wd;
      chk("R7", int'(sfr_wr_en), int'(commit && in_sfr(wa)));
      if (commit && in_sfr(wa)) begin
         chk("R7", int'(sfr_wr_addr), wa & 8'hFF);
         if (cdata >= 0) chk("R7", int'(sfr_wr_data), cdata);
      end
      @(posedge clk);
      m_done = v;
      if (ld) m_bank = lit & 4'hF;
      if (commit && !in_sfr(wa) && MASK[wa >> 8]) begin
         if (cdata >= 0) begin
            m_mem[wa] = cdata & 8'hFF;
            m_known[wa] = 1'b1;
         end else begin
            m_known[wa] = 1'b0;
         end
      end
   endtask

   task automatic reset_pulse();
      @(negedge clk);
      rst = 1'b1; op_valid = 1'b0; bsr_load = 1'b0;
      @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      #5;
      // R9: bank register and completion flag cleared
      chk("R9", int'(bsr_q), 0);
      chk("R9", int'(op_done), 0);
      m_bank = 0; m_done = 0;
   endtask

   initial begin
      #(200000 * 20);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; op_valid = 0; op_mode = 0; op_write = 0; op_offset = 0;
      op_wdata = 0; mv_src = 0; mv_dst = 0; bsr_load = 0; bsr_lit = 0;
      repeat (3) @(posedge clk);
      reset_pulse();

      // fill every bank through banked writes (R1, R5, R6)
      for (int b = 0; b < 16; b++) begin
         step(0, 0, 0, 0, 0, 0, 0, 1, b | 8'hA0);
         for (int o = 0; o < 256; o++)
            step(1, 0, 1, o, (b * 37 + o) & 8'hFF, 0, 0, 0, 0);
      end
      // read back each bank; unimplemented ones return zero (R6)
      for (int b = 0; b < 16; b++) begin
         step(0, 0, 0, 0, 0, 0, 0, 1, b);
         for (int o = 0; o < 256; o += 17) step(1, 0, 0, o, 0, 0, 0, 0, 0);
      end

      // R2: upper literal bits dropped, load cycle uses the old bank
      step(0, 0, 0, 0, 0, 0, 0, 1, 8'hF2);
      step(1, 0, 0, 8'h10, 0, 0, 0, 1, 8'h05);
      step(1, 0, 0, 8'h10, 0, 0, 0, 0, 0);

      // R3: window edges with a bank that differs from both targets
      step(1, 1, 0, 8'h5F, 0, 0, 0, 0, 0);
      step(1, 1, 0, 8'h60, 0, 0, 0, 0, 0);
      step(1, 1, 1, 8'h00, 8'hC3, 0, 0, 0, 0);
      step(1, 1, 1, 8'h7E, 8'h99, 0, 0, 0, 0);
      step(1, 1, 0, 8'hFF, 0, 0, 0, 0, 0);

      // R4: move ignores the bank and op_write
      step(1, 2, 0, 8'h12, 0, 12'h205, 12'h033, 0, 0);
      step(1, 0, 0, 8'h33, 0, 0, 0, 1, 0);
      step(1, 0, 0, 8'h33, 0, 0, 0, 0, 0);
      step(1, 2, 1, 0, 0, 12'hF81, 12'h510, 0, 0);
      step(1, 2, 0, 0, 0, 12'h510, 12'hF70, 0, 0);

      // R6 / R8: unimplemented write is dropped yet completes
      step(1, 2, 0, 0, 0, 12'h0AA, 12'h1AA, 0, 0);
      step(1, 2, 0, 0, 0, 12'h1AA, 12'h0AB, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);

      // R1: reserved code 3 behaves as banked
      step(0, 0, 0, 0, 0, 0, 0, 1, 2);
      step(1, 3, 1, 8'h44, 8'h6E, 0, 0, 0, 0);
      step(1, 0, 0, 8'h44, 0, 0, 0, 0, 0);

      // mixed traffic
      for (int i = 0; i < 3000; i++) begin
         int r;
         r = $urandom;
         step(r[0] | r[1], int'(r[3:2]), r[4], int'(r[15:8]), int'(r[23:16]),
              int'($urandom) & 12'hFFF, int'($urandom) & 12'hFFF,
              r[5] & r[6], int'(r[31:24]));
         if (i == 1500) reset_pulse();
      end

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule